// File: doc/BRIEF.md
# Configuration Image Streaming Writer

This block moves a configuration image into a device through a simple register master port. A sequencer pulses `start` and supplies the image length in bytes and a flag that turns status checking on. The image then arrives as 32-bit words on a valid/ready stream. Each accepted word becomes exactly one register write to the device data register. If the length is not a multiple of four, the last word has its unused upper bytes forced to zero before it is written.

With checking on, the writer reads the device status register each time the count of bytes written reaches a multiple of the check interval (4 KiB by default). It reads it once more after the last write. A set error bit ends the stream at once. The block then raises `done` together with `error`, and `bytes_done` reports how many bytes had been written when the error was seen. A zero length finishes without any register traffic.

The control is a six-state machine. IDLE waits for `start`. FETCH is the only state in which `in_ready` is high. WRITE holds a data write until it is acknowledged. PCHECK holds a periodic status read. FCHECK holds the closing status read. FINISH pulses `done` for one cycle.

The transitions are:
- IDLE→FETCH on start with a non-zero length.
- IDLE→FINISH on start with a zero length.
- FETCH→WRITE when a word is accepted.
- WRITE→PCHECK when the acknowledged word lands on an interval boundary with checking on.
- WRITE→FCHECK after the last word with checking on.
- WRITE→FINISH after the last word with checking off.
- WRITE→FETCH otherwise.
- PCHECK→FINISH when the error bit is seen.
- PCHECK→FCHECK when nothing remains.
- PCHECK→FETCH otherwise.
- FCHECK→FINISH.
- FINISH→IDLE.

Top module: `cfg_stream_writer`

## Requirements
- R1: After reset, `in_ready`, `reg_req` and `done` are low.
- R2: Every accepted full word is written once, in arrival order, unchanged, as a write (`reg_we`=1) to address `DATA_ADDR` (default 0x028).
- R3: When 1 to 3 bytes remain, one final word is written. Its byte lanes below the remaining count are kept (lane 0 is bits 7:0) and the other lanes are zero.
- R4: `in_ready` and `reg_req` are never high together. Once raised, `reg_req`, `reg_addr` and `reg_wdata` hold steady until `reg_ack`.
- R5: With checking on, a status read (`reg_we`=0, address `STATUS_ADDR`, default 0x01C) follows each full-word write that brings the written count to a multiple of `CHECK_BYTES` (default 4096).
- R6: With checking on and a non-zero length, one more status read follows the last write. This holds even when a periodic read came just before it.
- R7: A status read whose bit `ERR_BIT` (default 19) is set ends the stream: no further writes, `done` and `error` pulse together, and `bytes_done` equals the bytes written up to that read. Other status bits are ignored.
- R8: With checking off, no status reads are issued.
- R9: A zero length raises `done` in the cycle after the start edge, with no register requests.
- R10: `byte_count` and `check_en` are latched at `start`. A `start` pulse while a transfer is running is ignored.
- R11: `done` lasts one cycle, `error` is high only with `done`, and on success `bytes_done` equals the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| byte_count | input | CNT_W | Image length in bytes |
| check_en | input | 1 | Enable status error checking |
| in_valid | input | 1 | Image word valid |
| in_data | input | DATA_W | Image word, byte 0 in bits 7:0 |
| in_ready | output | 1 | Writer can take a word |
| reg_req | output | 1 | Register access request, held until ack |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Write data |
| reg_ack | input | 1 | Access complete (one cycle) |
| reg_rdata | input | DATA_W | Read data, valid with ack |
| done | output | 1 | Transfer finished (one-cycle pulse) |
| error | output | 1 | Finished because the status error bit was seen |
| bytes_done | output | CNT_W | Bytes written, valid with done |

## Verification
The hardest case to reach is an error on a periodic check that is not the first one. It needs an image longer than two check intervals, checking turned on, and a status responder that flags only one chosen read. The bench streams an 8194-byte image and sets the error bit on the second status read only. It then confirms that writing stopped at exactly 8192 bytes and that the pending trailing words were never taken. Random short images with random ragged tails, random source bubbles and random acknowledge delays cover the masking and the handshake interleavings. Random values in the other status bits show that only the error bit matters.

// File: rtl/csw_pkg.sv
package csw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE,
        ST_PCHECK,
        ST_FCHECK,
        ST_FINISH
    } csw_state_e;
endpackage

// File: rtl/csw_tracker.sv
module csw_tracker #(
    parameter int CNT_W       = 32,
    parameter int WORD_BYTES  = 4,
    parameter int CHECK_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [CNT_W-1:0]              load_bytes,
    input  logic                          step,
    output logic                          rem_zero,
    output logic                          last_step,
    output logic                          step_hits_chk,
    output logic [$clog2(WORD_BYTES)-1:0] tail_bytes,
    output logic [CNT_W-1:0]              written
);
    localparam int LANE_W  = $clog2(WORD_BYTES);
    localparam int CHK_LSB = $clog2(CHECK_BYTES);

    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] written_q;
    logic [CNT_W-1:0] step_amt;
    logic [CNT_W-1:0] next_written;
    logic             full;

    always_comb begin
        full          = rem_q >= CNT_W'(WORD_BYTES);
        step_amt      = full ? CNT_W'(WORD_BYTES) : rem_q;
        next_written  = written_q + step_amt;
        step_hits_chk = full && (next_written[CHK_LSB-1:0] == '0);
        last_step     = rem_q <= CNT_W'(WORD_BYTES);
        rem_zero      = rem_q == '0;
        tail_bytes    = full ? '0 : rem_q[LANE_W-1:0];
        written       = written_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            written_q <= '0;
        end else if (load) begin
            rem_q     <= load_bytes;
            written_q <= '0;
        end else if (step) begin
            rem_q     <= rem_q - step_amt;
            written_q <= next_written;
        end
    end
endmodule

// File: rtl/csw_lane_mask.sv
module csw_lane_mask #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [LANE_W-1:0] tail_bytes,
    output logic [DATA_W-1:0] word_out
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic keep;
        assign keep = (tail_bytes == '0) || (LANE_W'(g) < tail_bytes);
        assign word_out[8*g +: 8] = keep ? word_in[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/csw_reg_port.sv
module csw_reg_port #(
    parameter int              ADDR_W      = 12,
    parameter int              DATA_W      = 32,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 12'h028,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h01C,
    parameter int              ERR_BIT     = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_wr,
    input  logic              issue_rd,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              op_ack,
    output logic              err_seen
);
    localparam logic [DATA_W-1:0] ERR_MASK = DATA_W'(1) << ERR_BIT;

    logic              req_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (issue_wr) begin
            req_q   <= 1'b1;
            we_q    <= 1'b1;
            addr_q  <= DATA_ADDR;
            wdata_q <= wdata_in;
        end else if (issue_rd) begin
            req_q   <= 1'b1;
            we_q    <= 1'b0;
            addr_q  <= STATUS_ADDR;
        end else if (req_q && reg_ack) begin
            req_q   <= 1'b0;
        end
    end

    always_comb begin
        reg_req   = req_q;
        reg_we    = we_q;
        reg_addr  = addr_q;
        reg_wdata = wdata_q;
        op_ack    = req_q && reg_ack;
        err_seen  = req_q && reg_ack && !we_q && ((reg_rdata & ERR_MASK) != '0);
    end
endmodule

// File: rtl/cfg_stream_writer.sv
module cfg_stream_writer
    import csw_pkg::*;
#(
    parameter int                ADDR_W      = 12,
    parameter int                DATA_W      = 32,
    parameter int                CNT_W       = 32,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 12'h028,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h01C,
    parameter int                ERR_BIT     = 19,
    parameter int                CHECK_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              check_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              done,
    output logic              error,
    output logic [CNT_W-1:0]  bytes_done
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int LANE_W     = $clog2(WORD_BYTES);

    csw_state_e state_q, state_d;
    logic       chk_q;
    logic       err_q, err_d;
    logic       load, step, issue_wr, issue_rd;
    logic       rem_zero, last_step, step_hits_chk;
    logic       op_ack, err_seen;
    logic [LANE_W-1:0] tail_bytes;
    logic [DATA_W-1:0] masked;

    csw_tracker #(
        .CNT_W      (CNT_W),
        .WORD_BYTES (WORD_BYTES),
        .CHECK_BYTES(CHECK_BYTES)
    ) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .load_bytes   (byte_count),
        .step         (step),
        .rem_zero     (rem_zero),
        .last_step    (last_step),
        .step_hits_chk(step_hits_chk),
        .tail_bytes   (tail_bytes),
        .written      (bytes_done)
    );

    csw_lane_mask #(
        .DATA_W(DATA_W),
        .LANE_W(LANE_W)
    ) u_mask (
        .word_in   (in_data),
        .tail_bytes(tail_bytes),
        .word_out  (masked)
    );

    csw_reg_port #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .DATA_ADDR  (DATA_ADDR),
        .STATUS_ADDR(STATUS_ADDR),
        .ERR_BIT    (ERR_BIT)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_wr (issue_wr),
        .issue_rd (issue_rd),
        .wdata_in (masked),
        .reg_ack  (reg_ack),
        .reg_rdata(reg_rdata),
        .reg_req  (reg_req),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .op_ack   (op_ack),
        .err_seen (err_seen)
    );

    // State register and per-transfer flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chk_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (load) begin
                chk_q <= check_en;
            end
        end
    end

    // Transitions and the actions taken on them
    always_comb begin
        state_d  = state_q;
        err_d    = err_q;
        load     = 1'b0;
        step     = 1'b0;
        issue_wr = 1'b0;
        issue_rd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    err_d   = 1'b0;
                    state_d = (byte_count == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (in_valid) begin
                    issue_wr = 1'b1;
                    state_d  = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (op_ack) begin
                    step = 1'b1;
                    if (chk_q && step_hits_chk) begin
                        issue_rd = 1'b1;
                        state_d  = ST_PCHECK;
                    end else if (last_step) begin
                        issue_rd = chk_q;
                        state_d  = chk_q ? ST_FCHECK : ST_FINISH;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_PCHECK: begin
                if (op_ack) begin
                    if (err_seen) begin
                        err_d   = 1'b1;
                        state_d = ST_FINISH;
                    end else if (rem_zero) begin
                        issue_rd = 1'b1;
                        state_d  = ST_FCHECK;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FCHECK: begin
                if (op_ack) begin
                    err_d   = err_seen;
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        in_ready = state_q == ST_FETCH;
        done     = state_q == ST_FINISH;
        error    = (state_q == ST_FINISH) && err_q;
    end
endmodule

// File: rtl/cfg_stream_writer_chk.sv
module cfg_stream_writer_chk #(
    parameter int                ADDR_W      = 12,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] DATA_ADDR   = 12'h028,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 12'h01C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              reg_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_ack,
    input logic              chk_q,
    input logic              done,
    input logic              error
);
    // R4
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !reg_req);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_we)));
    // R2
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we) |-> (reg_addr == DATA_ADDR));
    // R5
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |-> (reg_addr == STATUS_ADDR));
    // R8
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_we) |-> chk_q);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    err_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);
endmodule

bind cfg_stream_writer cfg_stream_writer_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .DATA_ADDR  (DATA_ADDR),
    .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .reg_req  (reg_req),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_ack  (reg_ack),
    .chk_q    (chk_q),
    .done     (done),
    .error    (error)
);

// File: tb/tb_cfg_stream_writer.sv
`timescale 1ns/1ps
module tb_cfg_stream_writer;
    localparam int MAXW = 2100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] byte_count = '0;
    logic        check_en = 1'b0;
    logic        in_valid;
    logic [31:0] in_data;
    logic        in_ready;
    logic        reg_req, reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_ack;
    logic [31:0] reg_rdata;
    logic        done, error;
    logic [31:0] bytes_done;

    always #2 clk = ~clk;

    cfg_stream_writer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .check_en(check_en), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
        .reg_rdata(reg_rdata), .done(done), .error(error), .bytes_done(bytes_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic clr = 1'b0;
    logic [31:0] src_words [MAXW];
    logic [31:0] wr_log [MAXW];
    int src_n = 0;
    int src_idx;
    int wr_cnt, rd_cnt, bad_addr, lat;
    int inj = -1;

    // image source: holds valid until taken, random bubbles
    always @(posedge clk) begin
        if (clr || !rst_n) begin
            src_idx  <= 0;
            in_valid <= 1'b0;
            in_data  <= '0;
        end else if (in_valid && in_ready) begin
            src_idx  <= src_idx + 1;
            in_valid <= 1'b0;
        end else if (!in_valid && src_idx < src_n && ($urandom % 4) != 0) begin
            in_valid <= 1'b1;
            in_data  <= src_words[src_idx];
        end
    end

    // register responder with random latency
    always @(posedge clk) begin
        if (clr || !rst_n) begin
            reg_ack   <= 1'b0;
            reg_rdata <= '0;
            wr_cnt    <= 0;
            rd_cnt    <= 0;
            bad_addr  <= 0;
            lat       <= 0;
        end else if (reg_ack) begin
            reg_ack <= 1'b0;
        end else if (reg_req) begin
            if (lat == 0) begin
                reg_ack <= 1'b1;
                lat     <= $urandom % 3;
                if (reg_we) begin
                    if (wr_cnt < MAXW) wr_log[wr_cnt] <= reg_wdata;
                    wr_cnt <= wr_cnt + 1;
                    if (reg_addr != 12'h028) bad_addr <= bad_addr + 1;
                end else begin
                    reg_rdata <= (rd_cnt == inj) ? ($urandom | 32'h0008_0000)
                                                 : ($urandom & ~32'h0008_0000);
                    rd_cnt <= rd_cnt + 1;
                    if (reg_addr != 12'h01C) bad_addr <= bad_addr + 1;
                end
            end else begin
                lat <= lat - 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] w, input int left);
        logic [31:0] r;
        r = w;
        if (left == 1) r = w & 32'h0000_00FF;
        if (left == 2) r = w & 32'h0000_FFFF;
        if (left == 3) r = w & 32'h00FF_FFFF;
        return r;
    endfunction

    task automatic run_test(input int n, input bit chk, input int inj_at, input bit late_start);
        int nw, p, tot, e_wr, e_rd, e_bytes, bad;
        bit e_err;
        @(negedge clk);
        clr = 1'b1;
        nw = (n + 3) / 4;
        for (int i = 0; i < nw; i++) src_words[i] = $urandom;
        src_n = nw;
        inj = inj_at;
        @(negedge clk);
        clr = 1'b0;
        // expected outcome from the requirements
        p   = chk ? ((n / 4) * 4) / 4096 : 0;
        tot = (chk && n > 0) ? p + 1 : 0;
        e_err = 1'b0; e_wr = nw; e_rd = tot; e_bytes = n;
        if (inj_at >= 0 && inj_at < tot) begin
            e_err = 1'b1;
            e_rd  = inj_at + 1;
            if (inj_at < p) begin
                e_bytes = (inj_at + 1) * 4096;
                e_wr    = e_bytes / 4;
            end
        end
        byte_count = n;
        check_en   = chk;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            // R9: done one cycle after the start edge
            check(done === 1'b1, "R9 done after zero length", done, 1);
            check(wr_cnt == 0 && rd_cnt == 0 && reg_req == 0, "R9 no register traffic", wr_cnt + rd_cnt, 0);
        end
        if (late_start) begin
            repeat (10) @(negedge clk);
            byte_count = 12;
            check_en   = ~chk;
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        check(error == e_err, $sformatf("R7 error flag n=%0d", n), error, e_err);
        check(bytes_done == e_bytes, $sformatf("R7 R11 bytes_done n=%0d", n), bytes_done, e_bytes);
        check(wr_cnt == e_wr, $sformatf("R2 write count n=%0d%s", n, late_start ? " R10" : ""), wr_cnt, e_wr);
        check(rd_cnt == e_rd, $sformatf("R5 R6 R8 read count n=%0d chk=%0d", n, chk), rd_cnt, e_rd);
        bad = 0;
        for (int i = 0; i < e_wr && i < MAXW; i++)
            if (wr_log[i] !== exp_word(src_words[i], n - 4 * i)) begin
                if (bad == 0)
                    check(1'b0, $sformatf("R2 R3 write data word %0d", i), wr_log[i], exp_word(src_words[i], n - 4 * i));
                bad++;
            end
        if (bad == 0) check(1'b1, "R2 R3 write data", 0, 0);
        check(bad_addr == 0, "R2 R5 register address", bad_addr, 0);
        @(negedge clk);
        check(done === 1'b0, "R11 done single cycle", done, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd7321);
        #1;
        check(in_ready === 1'b0 && reg_req === 1'b0 && done === 1'b0, "R1 reset outputs",
              {in_ready, reg_req, done}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b0 && reg_req === 1'b0 && done === 1'b0, "R1 idle after reset",
              {in_ready, reg_req, done}, 0);
        // directed corners
        run_test(0, 1'b1, -1, 1'b0);
        run_test(3, 1'b1, 0, 1'b0);
        run_test(5, 1'b0, -1, 1'b0);
        run_test(4096, 1'b1, -1, 1'b0);
        run_test(4096, 1'b1, 0, 1'b0);
        run_test(8194, 1'b1, 1, 1'b0);
        run_test(100, 1'b1, -1, 1'b1);
        run_test(4100, 1'b0, 0, 1'b0);
        // random short images
        for (int t = 0; t < 14; t++) begin
            int n;
            bit c;
            n = $urandom % 401;
            c = $urandom % 2;
            run_test(n, c, (($urandom % 3) == 0) ? 0 : -1, 1'b0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule